// File: doc/BRIEF.md
# Slow-Clock Low-Level Wake Qualifier

This block runs on a slow, always-on clock while the main clock is stopped in a deep sleep mode. It watches one active-low interrupt pin for a low level. A wake request is accepted only when the pin reads low on two consecutive slow-clock samples. A single low sample followed by a high one is treated as noise and is discarded.

When a wake is accepted, the block emits a one-cycle wake pulse and starts a start-up countdown. The length of the countdown was latched when sleep began. When the countdown ends, the block looks at the pin again. If the pin is still low, it emits a one-cycle interrupt pulse. If the pin has gone high, it emits a one-cycle pulse that marks a wake-up with no interrupt. Exactly one of these two pulses follows each wake.

A sleep-entry strobe starts each sleep period and carries a deep/idle flag. In idle sleep the I/O clock keeps running, so ordinary clocked detection handles the pin and this qualifier stays passive.

Top module: `wake_level_qualifier`

## Requirements
- R1: After reset, and before any sleep-entry strobe, all three outputs stay low, even when `wake_pin_n` is held low.
- R2: In deep sleep, `wake_pulse` is high for one cycle when the synchronized pin (active low, 0 = request) reads low at two consecutive clock edges. With a two-stage synchronizer, a pin that is first low at edge k and still low at edge k+1 gives a wake pulse visible after edge k+3.
- R3: A high sample after a single low sample resets the qualification count to zero. A pin that alternates low and high on every cycle never causes a wake.
- R4: At most one `wake_pulse` is produced per sleep entry, however many further low pairs occur.
- R5: The start-up length D is taken from `startup_cycles` on the sleep-entry strobe. Later changes to that input have no effect until the next entry.
- R6: If the wake pulse appears after edge w and the synchronized pin is still low at edge w+D+1, then `irq_pulse` is high for one cycle after edge w+D+1. That synchronized sample reflects the raw pin at edge w+D−1.
- R7: If that same sample is high, `wake_only_pulse` is high for one cycle after edge w+D+1 instead, and `irq_pulse` stays low.
- R8: `irq_pulse` and `wake_only_pulse` are never high together. Exactly one of them follows each wake pulse.
- R9: A sleep entry with `sleep_deep` = 0 (idle sleep) never produces any output pulse.
- R10: A sleep-entry strobe aborts any qualification or start-up in progress, so no outcome pulse from the earlier wake appears. It clears all outputs in the next cycle and re-arms the qualifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| sleep_enter | input | 1 | One-cycle strobe marking entry into a sleep period |
| sleep_deep | input | 1 | Sampled with `sleep_enter`: 1 = deep sleep (qualifier active), 0 = idle sleep |
| wake_pin_n | input | 1 | Asynchronous interrupt pin, active low |
| startup_cycles | input | DLY_W | Start-up length D in slow-clock cycles, latched on `sleep_enter` |
| wake_pulse | output | 1 | One-cycle pulse when a low level has been qualified |
| irq_pulse | output | 1 | One-cycle pulse: the level was still present when start-up ended |
| wake_only_pulse | output | 1 | One-cycle pulse: the level was gone when start-up ended |

## Verification
The pin passes through two synchronizer stages. As a result, the wake pulse appears three edges after the first edge at which the raw pin is low, provided the pin is also low at the next edge. The outcome pulse follows the wake pulse by D+1 edges, and it depends on the raw pin value D−1 edges after the wake edge. The bench drives every input on falling edges and reads outputs on falling edges. It numbers the edges from the first low pin edge and records the cycle and the count of every pulse. It then compares these with cycle numbers worked out from the low-level pattern it applied and the latched D. A sweep covers every low duration from 0 to 8 cycles, every D from 0 to 4, and both sleep depths. Extra cases cover glitch patterns, a late change to the start-up input, and a re-entry during start-up.

// File: rtl/wkq_pkg.sv
`timescale 1ns/1ps
package wkq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ARMED   = 2'd1,
    PH_STARTUP = 2'd2,
    PH_DONE    = 2'd3
  } wkq_phase_e;
endpackage

// File: rtl/wkq_sync.sv
`timescale 1ns/1ps
module wkq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b1;
        else        chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/wkq_qualify.sv
`timescale 1ns/1ps
module wkq_qualify #(
  parameter int unsigned NEED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic low,
  output logic hit
);
  localparam int unsigned CW = (NEED < 2) ? 1 : $clog2(NEED + 1);
  localparam logic [CW-1:0] LAST = CW'(NEED - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign hit    = en && low && (cnt_q == LAST);
  assign cnt_en = clr || en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (!low)     cnt_d = '0;
    else if (hit)      cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_QUAL_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !low) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/wkq_startup_cnt.sv
`timescale 1ns/1ps
module wkq_startup_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dly,
  input  logic         run,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign done   = run && (cnt_q == '0);
  assign cnt_en = load || (run && (cnt_q != '0));

  always_comb begin
    if (load) cnt_d = dly;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
  AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/wake_level_qualifier.sv
`timescale 1ns/1ps
module wake_level_qualifier #(
  parameter int unsigned DLY_W        = 8,
  parameter int unsigned QUAL_SAMPLES = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             sleep_enter,
  input  logic             sleep_deep,
  input  logic             wake_pin_n,
  input  logic [DLY_W-1:0] startup_cycles,
  output logic             wake_pulse,
  output logic             irq_pulse,
  output logic             wake_only_pulse
);
  import wkq_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic pin_n_s, pin_low_s;

  wkq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_slow),
    .rst_n (rst_core_n),
    .d_in  (wake_pin_n),
    .d_out (pin_n_s)
  );
  assign pin_low_s = ~pin_n_s;

  wkq_phase_e phase_q, phase_d;
  logic       qual_en, qual_hit, cnt_run, cnt_done;

  assign qual_en = (phase_q == PH_ARMED) && !sleep_enter;
  assign cnt_run = (phase_q == PH_STARTUP) && !sleep_enter;

  wkq_qualify #(.NEED(QUAL_SAMPLES)) u_qual (
    .clk   (clk_slow),
    .rst_n (rst_core_n),
    .clr   (sleep_enter),
    .en    (qual_en),
    .low   (pin_low_s),
    .hit   (qual_hit)
  );

  wkq_startup_cnt #(.W(DLY_W)) u_cnt (
    .clk   (clk_slow),
    .rst_n (rst_core_n),
    .load  (sleep_enter),
    .dly   (startup_cycles),
    .run   (cnt_run),
    .done  (cnt_done)
  );

  always_comb begin
    phase_d = phase_q;
    if (sleep_enter) begin
      phase_d = sleep_deep ? PH_ARMED : PH_IDLE;
    end else begin
      case (phase_q)
        PH_ARMED:   if (qual_hit) phase_d = PH_STARTUP;
        PH_STARTUP: if (cnt_done) phase_d = PH_DONE;
        default:    phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk_slow or negedge rst_core_n) begin
    if (!rst_core_n) phase_q <= PH_IDLE;
    else             phase_q <= phase_d;
  end

  logic wake_d, irq_d, only_d;
  logic wake_q, irq_q, only_q;

  assign wake_d = qual_en && qual_hit;
  assign irq_d  = cnt_done && pin_low_s;
  assign only_d = cnt_done && !pin_low_s;

  always_ff @(posedge clk_slow or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wake_q <= 1'b0;
      irq_q  <= 1'b0;
      only_q <= 1'b0;
    end else begin
      wake_q <= wake_d;
      irq_q  <= irq_d;
      only_q <= only_d;
    end
  end

  assign wake_pulse      = wake_q;
  assign irq_pulse       = irq_q;
  assign wake_only_pulse = only_q;

  AST_OUTCOME_EXCL: assert property (@(posedge clk_slow) disable iff (!rst_core_n)
    !(irq_pulse && wake_only_pulse)); // R8
  AST_WAKE_SINGLE: assert property (@(posedge clk_slow) disable iff (!rst_core_n)
    wake_pulse |=> !wake_pulse); // R4
  AST_WAKE_TWO_LOW: assert property (@(posedge clk_slow) disable iff (!rst_core_n)
    wake_pulse |-> ($past(pin_low_s) && $past(pin_low_s, 2))); // R2
  AST_WAKE_ARMED_ONLY: assert property (@(posedge clk_slow) disable iff (!rst_core_n)
    wake_pulse |-> ($past(phase_q) == PH_ARMED)); // R9
  AST_IRQ_LEVEL: assert property (@(posedge clk_slow) disable iff (!rst_core_n)
    irq_pulse |-> $past(pin_low_s)); // R6
  AST_ONLY_LEVEL: assert property (@(posedge clk_slow) disable iff (!rst_core_n)
    wake_only_pulse |-> !$past(pin_low_s)); // R7
  AST_ENTRY_CLEARS: assert property (@(posedge clk_slow) disable iff (!rst_core_n)
    sleep_enter |=> (!wake_pulse && !irq_pulse && !wake_only_pulse)); // R10
endmodule

// File: tb/tb_wake_level_qualifier.sv
`timescale 1ns/1ps
module tb_wake_level_qualifier;
  localparam int DLY_W = 8;

  logic             clk_slow;
  logic             rst_n;
  logic             sleep_enter;
  logic             sleep_deep;
  logic             wake_pin_n;
  logic [DLY_W-1:0] startup_cycles;
  logic             wake_pulse, irq_pulse, wake_only_pulse;

  int n_tests = 0;
  int n_fail  = 0;

  wake_level_qualifier #(.DLY_W(DLY_W), .QUAL_SAMPLES(2), .SYNC_STAGES(2)) dut (
    .clk_slow        (clk_slow),
    .rst_n           (rst_n),
    .sleep_enter     (sleep_enter),
    .sleep_deep      (sleep_deep),
    .wake_pin_n      (wake_pin_n),
    .startup_cycles  (startup_cycles),
    .wake_pulse      (wake_pulse),
    .irq_pulse       (irq_pulse),
    .wake_only_pulse (wake_only_pulse)
  );

  initial clk_slow = 1'b0;
  always #10 clk_slow = ~clk_slow;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pat[i] = 1 means the pin is low at edge k+i (k = first pattern edge)
  task automatic run_pattern(input int d, input int d_late, input logic deep,
                             input logic [15:0] pat, input string tag);
    int exp_tw, exp_irq, exp_only, td, idx;
    int tw, ti, to, nw, ni, no;
    logic lvl;
    exp_tw = -1; exp_irq = -1; exp_only = -1;
    if (deep) begin
      for (int i = 1; i < 16; i++)
        if (exp_tw < 0 && pat[i] && pat[i-1]) exp_tw = i + 2;
    end
    if (exp_tw >= 0) begin
      td  = exp_tw + d + 1;
      idx = td - 2;
      lvl = (idx < 16) ? pat[idx] : 1'b0;
      if (lvl) exp_irq = td; else exp_only = td;
    end
    @(negedge clk_slow);
    startup_cycles = DLY_W'(d); sleep_deep = deep; sleep_enter = 1'b1; wake_pin_n = 1'b1;
    @(negedge clk_slow);
    sleep_enter = 1'b0; startup_cycles = DLY_W'(d_late);
    repeat (3) @(negedge clk_slow);
    wake_pin_n = ~pat[0];
    tw = -1; ti = -1; to = -1; nw = 0; ni = 0; no = 0;
    for (int t = 0; t < 28; t++) begin
      @(negedge clk_slow);
      if (wake_pulse)      begin nw++; if (tw < 0) tw = t; end
      if (irq_pulse)       begin ni++; if (ti < 0) ti = t; end
      if (wake_only_pulse) begin no++; if (to < 0) to = t; end
      wake_pin_n = (t + 1 < 16) ? ~pat[t+1] : 1'b1;
    end
    chk({tag, " wake cycle"}, tw, exp_tw);
    chk("R4 wake count", nw, (exp_tw >= 0) ? 1 : 0);
    chk("R6 irq cycle", ti, exp_irq);
    chk("R7 wake-only cycle", to, exp_only);
    chk("R8 outcome count", ni + no, (exp_tw >= 0) ? 1 : 0);
    wake_pin_n = 1'b1;
    repeat (2) @(negedge clk_slow);
  endtask

  initial begin
    rst_n = 1'b0; sleep_enter = 1'b0; sleep_deep = 1'b0;
    wake_pin_n = 1'b1; startup_cycles = '0;
    repeat (3) @(negedge clk_slow);
    chk("R1 reset wake", int'(wake_pulse), 0);
    chk("R1 reset irq", int'(irq_pulse), 0);
    chk("R1 reset wake-only", int'(wake_only_pulse), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_slow);

    // R1: pin low without any sleep entry
    begin
      int cnt = 0;
      wake_pin_n = 1'b0;
      for (int t = 0; t < 12; t++) begin
        @(negedge clk_slow);
        cnt += int'(wake_pulse) + int'(irq_pulse) + int'(wake_only_pulse);
      end
      chk("R1 no pulse before sleep entry", cnt, 0);
      wake_pin_n = 1'b1;
      repeat (3) @(negedge clk_slow);
    end

    // R2/R6/R7/R9 sweep: low duration L, start-up D, depth
    for (int dp = 0; dp < 2; dp++)
      for (int d = 0; d <= 4; d++)
        for (int l = 0; l <= 8; l++)
          run_pattern(d, d, dp[0], 16'((1 << l) - 1), dp ? "R2" : "R9");

    // R3 glitch patterns
    run_pattern(2, 2, 1'b1, 16'b0101_0101_0101_0101, "R3");
    run_pattern(1, 1, 1'b1, 16'b0000_0000_0110_0101, "R3");
    run_pattern(3, 3, 1'b1, 16'b1111_1110_1010_1001, "R3");
    // R4: many low pairs, one wake
    run_pattern(0, 0, 1'b1, 16'b1100_1100_1111_0011, "R4");
    // R5: late change of the start-up input is ignored
    run_pattern(2, 7, 1'b1, 16'hFFFF, "R5");
    run_pattern(4, 0, 1'b1, 16'h003F, "R5");

    // R10: re-entry during start-up
    begin
      int nw = 0, ni = 0, no = 0, tw2 = -1, ti = -1;
      @(negedge clk_slow);
      startup_cycles = 8'd6; sleep_deep = 1'b1; sleep_enter = 1'b1; wake_pin_n = 1'b1;
      @(negedge clk_slow);
      sleep_enter = 1'b0;
      repeat (3) @(negedge clk_slow);
      wake_pin_n = 1'b0;
      for (int t = 0; t < 24; t++) begin
        @(negedge clk_slow);
        if (wake_pulse) begin nw++; if (t > 3) tw2 = t; end
        if (irq_pulse) begin ni++; if (ti < 0) ti = t; end
        if (wake_only_pulse) no++;
        sleep_enter = (t == 5);
      end
      chk("R10 wake count after re-entry", nw, 2);
      chk("R10 second wake cycle", tw2, 8);
      chk("R10 irq cycle after re-entry", ti, 15);
      chk("R10 irq count", ni, 1);
      chk("R10 no wake-only", no, 0);
      wake_pin_n = 1'b1;
      repeat (3) @(negedge clk_slow);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule